// File: doc/BRIEF.md
# External Byte Memory Bus Sequencer

This block moves single bytes between a CPU-side request port and an external memory of up to 64K bytes. The memory is wired to general-purpose port pins that normally carry the values of their port output registers. The pins are borrowed only for the length of one transfer. A transfer fills exactly one machine cycle of two system clocks. The sequencer lays that cycle out as four half-clock slots, numbered 0 to 3. A `half_tick` input pulses once per system half-period and is the time base for all strobe edges.

A request is presented with `req_valid`, a 16-bit address, a direction bit and write data. It is taken on the clock edge where `req_valid` and `req_ready` are both high. For the four slots that follow, the sequencer owns the address pins, the data pins and the two active-low strobes. A write pulses the write strobe low in slot 2 only, while the data pins drive the byte in all four slots. A read releases the data pins, drives the read strobe low in slots 2 and 3, and samples the incoming byte on the final half tick. Both kinds of transfer end with a one-cycle `rsp_done` pulse. After that, every pin again shows its port register value.

Top module: `xmem_byte_bus`

## Requirements
- R1: While `rst` is high, `rsp_done` is 0, `rsp_rdata` is 0 and every bus pin equals its port register input.
- R2: With no transfer in progress, `bus_addr`, `bus_data_out`, `bus_data_oe`, `bus_rd_n` and `bus_wr_n` equal `port_addr`, `port_data`, `port_data_oe`, `port_rd_n` and `port_wr_n`, and follow changes on those inputs at once.
- R3: `req_ready` is high only when no transfer is in progress and `half_tick` is high. A request is accepted on a clock edge with `req_valid`, `req_ready` and `half_tick` all high. `req_ready` then stays low through all four slots.
- R4: In all four slots of a transfer, `bus_addr` carries the accepted address.
- R5: In a write (`req_write` = 1), `bus_wr_n` is 0 in slot 2 and 1 in slots 0, 1 and 3, and `bus_rd_n` stays 1.
- R6: In a write, `bus_data_oe` is 1 and `bus_data_out` carries the accepted write byte in all four slots.
- R7: In a read (`req_write` = 0), `bus_data_oe` is 0 in all slots, `bus_rd_n` is 1 in slots 0 and 1 and 0 in slots 2 and 3, and `bus_wr_n` stays 1.
- R8: A read captures `bus_data_in` on the half tick that ends slot 3. In the following clock cycle, `rsp_rdata` holds that byte and `rsp_done` is 1.
- R9: `rsp_done` is a pulse of a single clock cycle, given in the cycle after the last half tick of every transfer. A write leaves `rsp_rdata` unchanged.
- R10: From the cycle that carries `rsp_done`, every bus pin shows its port register input again.
- R11: A request held valid when `rsp_done` appears is accepted on the next half tick, within one tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse per system half-period |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle pulse at transfer end |
| rsp_rdata | output | 8 | Last byte read |
| port_addr | input | 16 | Port register value for the address pins |
| port_data | input | 8 | Port register value for the data pins |
| port_data_oe | input | 1 | Port output enable for the data pins |
| port_rd_n | input | 1 | Port register value for the read strobe pin |
| port_wr_n | input | 1 | Port register value for the write strobe pin |
| bus_addr | output | 16 | Address pins |
| bus_data_out | output | 8 | Data pin drive value |
| bus_data_oe | output | 1 | Data pin output enable |
| bus_data_in | input | 8 | Data pin input value |
| bus_rd_n | output | 1 | Read strobe pin, active low |
| bus_wr_n | output | 1 | Write strobe pin, active low |

## Verification
The bench uses the default 16-bit address and 8-bit data widths, so transfers at both 16'h0000 and 16'hFFFF are possible. It generates `half_tick` once every three clocks. Every slot therefore spans several clock cycles, and a strobe or capture that moves on the clock instead of the tick is exposed. During a read, the bench drives a wrong byte on the data input until slot 3 begins. This separates capture at the last tick from any earlier sample.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_ADDR_W = 16;
  localparam int XB_DATA_W = 8;

  typedef enum logic [1:0] {
    SLOT_LEAD  = 2'd0,
    SLOT_SETUP = 2'd1,
    SLOT_STB   = 2'd2,
    SLOT_LAST  = 2'd3
  } slot_e;

  typedef struct packed {
    logic  busy;
    logic  is_write;
    slot_e slot;
  } seq_state_t;
endpackage

// File: rtl/xbus_slot_seq.sv
module xbus_slot_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = XB_ADDR_W,
  parameter int DATA_W = XB_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output seq_state_t        st,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              last_tick
);
  assign req_ready = !st.busy && half_tick;
  assign last_tick = st.busy && half_tick && (st.slot == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '{busy: 1'b0, is_write: 1'b0, slot: SLOT_LEAD};
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (half_tick) begin
      if (!st.busy) begin
        if (req_valid) begin
          st.busy     <= 1'b1;
          st.is_write <= req_write;
          st.slot     <= SLOT_LEAD;
          lat_addr    <= req_addr;
          lat_wdata   <= req_wdata;
        end
      end else if (st.slot == SLOT_LAST) begin
        st.busy <= 1'b0;
        st.slot <= SLOT_LEAD;
      end else begin
        st.slot <= slot_e'(st.slot + 2'd1);
      end
    end
  end
endmodule

// File: rtl/xbus_pin_mux.sv
module xbus_pin_mux
  import xbus_pkg::*;
#(
  parameter int ADDR_W = XB_ADDR_W,
  parameter int DATA_W = XB_DATA_W
) (
  input  seq_state_t        st,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] port_data,
  input  logic              port_data_oe,
  input  logic              port_rd_n,
  input  logic              port_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  logic strobe_slot;
  logic read_slot;

  assign strobe_slot = (st.slot == SLOT_STB);
  assign read_slot   = (st.slot == SLOT_STB) || (st.slot == SLOT_LAST);

  for (genvar a = 0; a < ADDR_W; a++) begin : g_addr
    assign bus_addr[a] = st.busy ? lat_addr[a] : port_addr[a];
  end

  for (genvar d = 0; d < DATA_W; d++) begin : g_data
    assign bus_data_out[d] = st.busy ? lat_wdata[d] : port_data[d];
  end

  always_comb begin
    if (st.busy) begin
      bus_data_oe = st.is_write;
      bus_wr_n    = !(st.is_write && strobe_slot);
      bus_rd_n    = !(!st.is_write && read_slot);
    end else begin
      bus_data_oe = port_data_oe;
      bus_wr_n    = port_wr_n;
      bus_rd_n    = port_rd_n;
    end
  end
endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture
  import xbus_pkg::*;
#(
  parameter int DATA_W = XB_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_tick,
  input  logic              is_write,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= last_tick;
      if (last_tick && !is_write) rsp_rdata <= bus_data_in;
    end
  end
endmodule

// File: rtl/xmem_byte_bus.sv
module xmem_byte_bus
  import xbus_pkg::*;
#(
  parameter int ADDR_W = XB_ADDR_W,
  parameter int DATA_W = XB_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] port_data,
  input  logic              port_data_oe,
  input  logic              port_rd_n,
  input  logic              port_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  seq_state_t        st;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              last_tick;
  logic              xfer_busy;

  assign xfer_busy = st.busy;

  xbus_slot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst(rst), .half_tick(half_tick),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .st(st),
    .lat_addr(lat_addr), .lat_wdata(lat_wdata), .last_tick(last_tick)
  );

  xbus_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mux (
    .st(st), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .port_addr(port_addr), .port_data(port_data), .port_data_oe(port_data_oe),
    .port_rd_n(port_rd_n), .port_wr_n(port_wr_n),
    .bus_addr(bus_addr), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  xbus_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk(clk), .rst(rst), .last_tick(last_tick), .is_write(st.is_write),
    .bus_data_in(bus_data_in), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
  );
endmodule

// File: rtl/xmem_byte_bus_chk.sv
module xmem_byte_bus_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data_out,
  input logic              bus_data_oe,
  input logic              bus_rd_n,
  input logic              bus_wr_n
);
  p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_setup_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && $fell(bus_wr_n)) |-> $stable(bus_addr));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && $rose(bus_wr_n)) |-> (bus_data_oe && $stable(bus_data_out)));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |-> (bus_rd_n || bus_wr_n));

  p_rd_float_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && !bus_rd_n) |-> !bus_data_oe);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

bind xmem_byte_bus xmem_byte_bus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .xfer_busy(xfer_busy),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_done(rsp_done),
  .bus_addr(bus_addr), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/test_xmem_byte_bus.sv
module test_xmem_byte_bus;
  localparam int TICK_DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        half_tick;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [15:0] port_addr = 16'h1234;
  logic [7:0]  port_data = 8'h5A;
  logic        port_data_oe = 1'b1;
  logic        port_rd_n = 1'b1;
  logic        port_wr_n = 1'b1;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data_out;
  logic        bus_data_oe;
  logic [7:0]  bus_data_in = 8'h00;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic [1:0]  tcnt;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else     tcnt <= (tcnt == 2'(TICK_DIV - 1)) ? 2'd0 : tcnt + 2'd1;
  end
  assign half_tick = (tcnt == 2'd0);

  xmem_byte_bus i_xmem_byte_bus (
    .clk(clk), .rst(rst), .half_tick(half_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .port_addr(port_addr), .port_data(port_data), .port_data_oe(port_data_oe),
    .port_rd_n(port_rd_n), .port_wr_n(port_wr_n),
    .bus_addr(bus_addr), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_data_in(bus_data_in), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk({req, " addr"}, 32'(bus_addr), 32'(port_addr));
    chk({req, " dout"}, 32'(bus_data_out), 32'(port_data));
    chk({req, " oe"}, 32'(bus_data_oe), 32'(port_data_oe));
    chk({req, " rd_n"}, 32'(bus_rd_n), 32'(port_rd_n));
    chk({req, " wr_n"}, 32'(bus_wr_n), 32'(port_wr_n));
  endtask

  // one complete transfer; returns the cycles spent waiting for acceptance
  task automatic run_xfer(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                          input logic [7:0] rd_byte, output int waited);
    logic [7:0] prev_rdata;
    prev_rdata = rsp_rdata;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    bus_data_in = ~rd_byte;
    waited = 0;
    @(negedge clk);
    while (!(req_ready && req_valid) && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk("R3 accepted", 32'(waited < 20), 32'd1);
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < TICK_DIV; k++) begin
        @(negedge clk);
        if (s == 0 && k == 0) req_valid = 1'b0;
        if (s == 3 && k == 0) bus_data_in = rd_byte;
        chk("R3 ready low", 32'(req_ready), 32'd0);
        chk("R4 addr", 32'(bus_addr), 32'(a));
        if (wr) begin
          chk("R5 wr_n", 32'(bus_wr_n), 32'(s != 2));
          chk("R5 rd_n", 32'(bus_rd_n), 32'd1);
          chk("R6 oe", 32'(bus_data_oe), 32'd1);
          chk("R6 dout", 32'(bus_data_out), 32'(wd));
        end else begin
          chk("R7 oe", 32'(bus_data_oe), 32'd0);
          chk("R7 rd_n", 32'(bus_rd_n), 32'(s < 2));
          chk("R7 wr_n", 32'(bus_wr_n), 32'd1);
        end
        chk("R9 no early done", 32'(rsp_done), 32'd0);
      end
    end
    @(negedge clk);
    chk("R9 done", 32'(rsp_done), 32'd1);
    if (wr) chk("R9 rdata kept", 32'(rsp_rdata), 32'(prev_rdata));
    else    chk("R8 rdata", 32'(rsp_rdata), 32'(rd_byte));
    chk_idle("R10");
    bus_data_in = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(rsp_done), 32'd0);
    chk("R1 rdata", 32'(rsp_rdata), 32'd0);
    chk_idle("R1");
  endtask

  task automatic t_idle();
    port_addr = 16'hBEEF; port_data = 8'hC3; port_data_oe = 1'b0;
    port_rd_n = 1'b0; port_wr_n = 1'b1;
    #1 chk_idle("R2 a");
    port_addr = 16'h0F0F; port_data = 8'h3C; port_data_oe = 1'b1;
    port_rd_n = 1'b1; port_wr_n = 1'b0;
    #1 chk_idle("R2 b");
    repeat (4) @(negedge clk);
    chk_idle("R2 c");
    port_rd_n = 1'b1; port_wr_n = 1'b1;
  endtask

  task automatic t_writes();
    int w;
    run_xfer(1'b1, 16'hA55A, 8'h96, 8'h00, w);
    run_xfer(1'b1, 16'hFFFF, 8'hFF, 8'h00, w);
    run_xfer(1'b1, 16'h0000, 8'h00, 8'h00, w);
  endtask

  task automatic t_reads();
    int w;
    run_xfer(1'b0, 16'h1357, 8'h00, 8'hE7, w);
    run_xfer(1'b0, 16'hFFFF, 8'h00, 8'h18, w);
    run_xfer(1'b1, 16'h2222, 8'h44, 8'h00, w);
    @(negedge clk);
    chk("R9 single pulse", 32'(rsp_done), 32'd0);
    chk("R9 rdata after write", 32'(rsp_rdata), 32'h18);
  endtask

  task automatic t_back_to_back();
    int w;
    run_xfer(1'b0, 16'h8001, 8'h00, 8'h81, w);
    run_xfer(1'b1, 16'h8002, 8'h7E, 8'h00, w);
    chk("R11 wait", 32'(w <= TICK_DIV), 32'd1);
    run_xfer(1'b0, 16'h8003, 8'h00, 8'h42, w);
    chk("R11 wait 2", 32'(w <= TICK_DIV), 32'd1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_idle();
    t_writes();
    t_reads();
    t_back_to_back();
    repeat (3) @(negedge clk);
    chk_idle("R10 final");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule